// File: doc/BRIEF.md
# Nibble-Accessed 8-bit Reload Timer

This block is an 8-bit up-counter for a microcontroller whose data bus is four bits wide. Software reaches the counter through two neighbouring nibble addresses. Writes at those addresses fill a write-only load register. Reads at the same addresses return the counter through a capture latch, so the two halves of a read always belong to the same count.

A 4-bit mode register sets the count source and the overflow behaviour. The source is either one of seven taps of a free-running system-clock prescaler or the rising edges of an external event pin, which pass through a synchronizer first. When the counter is at its top value and receives one more count, it overflows. It then restarts either from the load register or from zero, and it sets a sticky interrupt request flag that software clears.

The whole block runs on the system clock. Every count source acts as a one-cycle clock enable, so the block has a single clock domain apart from the synchronized event pin.

Top module: `nib_reload_timer`

## Requirements
- R1: After reset the counter, load register, capture latch, mode register and interrupt flag are all zero. A full count read and a flag read therefore both return 0.
- R2: A write to address 0x0A stores the lower four bits of the load register and leaves the counter unchanged. A write to address 0x0B stores the upper four bits and, on the same clock edge, puts {written nibble, stored lower nibble} into the counter.
- R3: A read of address 0x0B returns counter bits 7:4 in the same cycle and captures all eight counter bits into the latch. A later read of 0x0A returns latch bits 3:0, even if the counter has moved on since the capture.
- R4: The mode register is at address 0x09. Bit 3 enables reload on overflow. Bits 2:0 select the count source, and 0b000 selects the event pin. While the event source is selected and the pin stays low, the counter holds its value.
- R5: In event mode each rising edge of the event pin adds one to the counter, on the third rising clock edge after the pin goes high. A pin held high does not add further counts.
- R6: Source codes 1 to 7 give one count every 2, 4, 8, 32, 128, 512 and 2048 system-clock cycles respectively.
- R7: A count that arrives while the counter holds 0xFF, with bit 3 of the mode register set, loads the counter from the load register.
- R8: A count that arrives while the counter holds 0xFF, with bit 3 of the mode register clear, sets the counter to 0x00.
- R9: Every overflow sets the interrupt flag. The flag drives the irq_flag output and reads back as bit 0 at address 0x02. Writing 0 to that bit clears the flag, and writing 1 leaves it unchanged.
- R10: When an upper-nibble write and a count land on the same clock edge, the counter takes the load value and that count is lost.
- R11: When an overflow and a flag-clearing write land on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 4 | Write data nibble |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 4 | Read data, valid in the same cycle as bus_rd |
| evt_in | input | 1 | External event input, asynchronous |
| irq_flag | output | 1 | Sticky overflow interrupt request |

## Verification
Each result has its own latency. The counter and the load register change on the first clock edge after a write. Upper-nibble read data is valid in the same cycle as the strobe, and the latch fills on that strobe's edge. An event edge reaches the counter on the third clock edge after the pin rises, and the flag follows an overflow by one edge. The bench drives every access on the falling edge and samples read data 1 ns later, so a value sampled there is always the settled one. For event counts it holds the pin high for three cycles and low for three more before it reads. For prescaler rates it compares two captures taken exactly M cycles apart. The two same-edge collisions are reached by starting the bus write two falling edges after the pin rises.

// File: rtl/ntmr_pkg.sv
`timescale 1ns/1ps
package ntmr_pkg;

   typedef struct packed {
      logic       reload;
      logic [2:0] src;
   } ntmr_mode_t;

   // divider exponent for each source code; 0 means external event
   function automatic int unsigned ntmr_tap_log2(input logic [2:0] src);
      case (src)
         3'd1:    return 1;
         3'd2:    return 2;
         3'd3:    return 3;
         3'd4:    return 5;
         3'd5:    return 7;
         3'd6:    return 9;
         3'd7:    return 11;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/ntmr_prescaler.sv
`timescale 1ns/1ps
module ntmr_prescaler #(
   parameter int PRESC_W = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] src,
   output logic       tick
);
   import ntmr_pkg::*;

   localparam int MAX_LOG2 = 11;

   if (PRESC_W < MAX_LOG2) begin : g_bad_width
      $error("ntmr_prescaler: PRESC_W must cover the largest tap");
   end

   logic [PRESC_W-1:0] div_q;
   logic [PRESC_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   always_comb begin
      mask = '0;
      for (int i = 0; i < PRESC_W; i++) begin
         if (i < int'(ntmr_tap_log2(src))) mask[i] = 1'b1;
      end
      tick = (src != 3'd0) && ((div_q & mask) == mask);
   end

endmodule

// File: rtl/ntmr_evsync.sv
`timescale 1ns/1ps
module ntmr_evsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_in,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ntmr_evsync: at least two synchronizer stages required");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], evt_in};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/ntmr_counter.sv
`timescale 1ns/1ps
module ntmr_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             ce,
   input  logic             reload_en,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);

   logic at_top;

   assign at_top = (cnt == {CNT_W{1'b1}});
   assign ovf    = ce && !load && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (ce) begin
         if (at_top) cnt <= reload_en ? reload_val : '0;
         else        cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/nib_reload_timer.sv
`timescale 1ns/1ps
module nib_reload_timer #(
   parameter int              ADDR_W      = 6,
   parameter int              NIB_W       = 4,
   parameter int              CNT_W       = 8,
   parameter int              PRESC_W     = 11,
   parameter int              SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ADDR_FLAG = 6'h02,
   parameter logic [ADDR_W-1:0] ADDR_MODE = 6'h09,
   parameter logic [ADDR_W-1:0] ADDR_LO   = 6'h0A,
   parameter logic [ADDR_W-1:0] ADDR_HI   = 6'h0B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [NIB_W-1:0]  bus_wdata,
   input  logic              bus_rd,
   output logic [NIB_W-1:0]  bus_rdata,
   input  logic              evt_in,
   output logic              irq_flag
);
   import ntmr_pkg::*;

   localparam int HI_W = CNT_W - NIB_W;

   if (CNT_W != 2 * NIB_W) begin : g_bad_split
      $error("nib_reload_timer: counter must be exactly two nibbles");
   end
   if (NIB_W < 4) begin : g_bad_nib
      $error("nib_reload_timer: mode register needs a 4-bit bus");
   end

   logic             wr_lo, wr_hi, wr_mode, wr_flag;
   logic             rd_lo, rd_hi, rd_flag;
   logic [CNT_W-1:0] tlr_q;
   logic [CNT_W-1:0] latch_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ld_val;
   ntmr_mode_t       mode_q;
   logic             flag_q;
   logic             flag_clr;
   logic             ld_stb;
   logic             presc_tick, evt_rise, cnt_ce, ovf;

   assign wr_lo   = bus_wr && (bus_addr == ADDR_LO);
   assign wr_hi   = bus_wr && (bus_addr == ADDR_HI);
   assign wr_mode = bus_wr && (bus_addr == ADDR_MODE);
   assign wr_flag = bus_wr && (bus_addr == ADDR_FLAG);
   assign rd_lo   = bus_rd && (bus_addr == ADDR_LO);
   assign rd_hi   = bus_rd && (bus_addr == ADDR_HI);
   assign rd_flag = bus_rd && (bus_addr == ADDR_FLAG);

   assign ld_stb   = wr_hi;
   assign ld_val   = {bus_wdata[HI_W-1:0], tlr_q[NIB_W-1:0]};
   assign flag_clr = wr_flag && !bus_wdata[0];

   ntmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (mode_q.src),
      .tick  (presc_tick)
   );

   ntmr_evsync #(.STAGES(SYNC_STAGES)) u_evsync (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_in (evt_in),
      .rise   (evt_rise)
   );

   assign cnt_ce = (mode_q.src == 3'd0) ? evt_rise : presc_tick;

   ntmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ld_stb),
      .load_val   (ld_val),
      .ce         (cnt_ce),
      .reload_en  (mode_q.reload),
      .reload_val (tlr_q),
      .cnt        (cnt_q),
      .ovf        (ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tlr_q   <= '0;
         mode_q  <= '0;
         latch_q <= '0;
         flag_q  <= 1'b0;
      end else begin
         if (wr_lo)   tlr_q[NIB_W-1:0]     <= bus_wdata;
         if (wr_hi)   tlr_q[CNT_W-1:NIB_W] <= bus_wdata[HI_W-1:0];
         if (wr_mode) mode_q               <= ntmr_mode_t'(bus_wdata[3:0]);
         if (rd_hi)   latch_q              <= cnt_q;
         if (ovf)           flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_hi)        bus_rdata = cnt_q[CNT_W-1:NIB_W];
      else if (rd_lo)   bus_rdata = latch_q[NIB_W-1:0];
      else if (rd_flag) bus_rdata[0] = flag_q;
   end

   assign irq_flag = flag_q;

endmodule

// File: rtl/ntmr_chk.sv
`timescale 1ns/1ps
module ntmr_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_stb,
   input logic [CNT_W-1:0] ld_val,
   input logic [CNT_W-1:0] cnt_q,
   input logic             cnt_ce,
   input logic             reload_en,
   input logic [CNT_W-1:0] tlr_q,
   input logic             ovf,
   input logic             flag_q,
   input logic             flag_clr,
   input logic             rd_hi,
   input logic [CNT_W-1:0] latch_q
);

   // R2, R10: an upper-nibble write always lands in the counter
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |=> cnt_q == $past(ld_val));

   // R5: one step per enable below the top value
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ce && !ld_stb && cnt_q != {CNT_W{1'b1}}) |=>
         cnt_q == CNT_W'($past(cnt_q) + 1'b1));

   // R4: no enable and no load means the counter holds
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_ce && !ld_stb) |=> $stable(cnt_q));

   // R7: wrap with reload
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ce && !ld_stb && cnt_q == {CNT_W{1'b1}} && reload_en) |=>
         cnt_q == $past(tlr_q));

   // R8: wrap without reload
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ce && !ld_stb && cnt_q == {CNT_W{1'b1}} && !reload_en) |=>
         cnt_q == '0);

   // R9, R11: overflow sets the flag whatever the bus does
   a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> flag_q);

   // R9: only a clearing write drops the flag
   a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q);

   // R3: upper read captures the full count
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |=> latch_q == $past(cnt_q));

endmodule

bind nib_reload_timer ntmr_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_stb    (ld_stb),
   .ld_val    (ld_val),
   .cnt_q     (cnt_q),
   .cnt_ce    (cnt_ce),
   .reload_en (mode_q.reload),
   .tlr_q     (tlr_q),
   .ovf       (ovf),
   .flag_q    (flag_q),
   .flag_clr  (flag_clr),
   .rd_hi     (rd_hi),
   .latch_q   (latch_q)
);

// File: tb/nib_reload_timer_tb.sv
`timescale 1ns/1ps
module nib_reload_timer_tb_top;

   localparam logic [5:0] A_FLAG = 6'h02;
   localparam logic [5:0] A_MODE = 6'h09;
   localparam logic [5:0] A_LO   = 6'h0A;
   localparam logic [5:0] A_HI   = 6'h0B;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [3:0] bus_rdata;
   logic       evt_in = 1'b0;
   logic       irq_flag;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   nib_reload_timer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .evt_in    (evt_in),
      .irq_flag  (irq_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [3:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic load8(input logic [7:0] v);
      wr(A_LO, v[3:0]);
      wr(A_HI, v[7:4]);
   endtask

   task automatic rd_count(output logic [7:0] v);
      @(negedge clk);
      bus_addr = A_HI; bus_rd = 1'b1;
      #1 v[7:4] = bus_rdata;
      @(negedge clk);
      bus_addr = A_LO;
      #1 v[3:0] = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_flag(output logic f);
      @(negedge clk);
      bus_addr = A_FLAG; bus_rd = 1'b1;
      #1 f = bus_rdata[0];
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_evt();
      @(negedge clk);
      evt_in = 1'b1;
      repeat (3) @(negedge clk);
      evt_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // expected counter step for one count
   function automatic logic [7:0] model_step(input logic [7:0] v,
                                             input logic rel,
                                             input logic [7:0] tlr);
      if (v == 8'hFF) return rel ? tlr : 8'h00;
      return v + 8'h01;
   endfunction

   task automatic rate_check(input logic [2:0] src, input int period,
                             input int win, input string req);
      logic [7:0] a, b;
      wr(A_MODE, {1'b0, src});
      load8(8'h00);
      rd_count(a);
      repeat (win - 3) @(negedge clk);
      rd_count(b);
      chk(req, int'(b - a), (win / period) % 256);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v, m, tlr;
      logic       f, ef, rel;
      int         n;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd_count(v);
      chk("R1 count after reset", v, 8'h00);
      rd_flag(f);
      chk("R1 flag after reset", f, 0);
      chk("R1 irq pin after reset", irq_flag, 0);

      // R4: event source, pin low, counter holds
      repeat (50) @(negedge clk);
      rd_count(v);
      chk("R4 event mode holds without edges", v, 8'h00);

      // R2: lower write alone leaves the counter
      wr(A_LO, 4'h7);
      rd_count(v);
      chk("R2 lower write does not load", v, 8'h00);
      wr(A_HI, 4'hC);
      rd_count(v);
      chk("R2 upper write loads full value", v, 8'hC7);

      // R5: one edge, held high, counts once
      load8(8'h10);
      @(negedge clk); evt_in = 1'b1;
      repeat (20) @(negedge clk);
      evt_in = 1'b0;
      repeat (3) @(negedge clk);
      rd_count(v);
      chk("R5 held level counts once", v, 8'h11);

      // R3: latched lower nibble survives a count
      load8(8'h3F);
      @(negedge clk);
      bus_addr = A_HI; bus_rd = 1'b1;
      #1 v[7:4] = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      chk("R3 upper read value", v[7:4], 4'h3);
      pulse_evt();
      @(negedge clk);
      bus_addr = A_LO; bus_rd = 1'b1;
      #1 v[3:0] = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      chk("R3 lower read from latch", v[3:0], 4'hF);
      rd_count(v);
      chk("R3 fresh capture", v, 8'h40);

      // R7: overflow with reload, R9 flag
      wr(A_MODE, 4'h8);
      wr(A_FLAG, 4'h0);
      load8(8'hFE);
      pulse_evt();
      pulse_evt();
      rd_count(v);
      chk("R7 reload on overflow", v, 8'hFE);
      rd_flag(f);
      chk("R9 flag set by overflow", f, 1);
      wr(A_FLAG, 4'h1);
      rd_flag(f);
      chk("R9 writing one keeps flag", f, 1);
      wr(A_FLAG, 4'h0);
      rd_flag(f);
      chk("R9 writing zero clears flag", f, 0);
      chk("R9 irq pin follows flag", irq_flag, 0);

      // R8: overflow without reload
      wr(A_MODE, 4'h0);
      load8(8'hFF);
      pulse_evt();
      rd_count(v);
      chk("R8 clear on overflow", v, 8'h00);

      // R10: load and count on the same edge
      wr(A_LO, 4'h5);
      @(negedge clk); evt_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = A_HI; bus_wdata = 4'hA; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; evt_in = 1'b0;
      repeat (3) @(negedge clk);
      rd_count(v);
      chk("R10 load beats count", v, 8'hA5);

      // R11: overflow and clear on the same edge
      wr(A_FLAG, 4'h0);
      load8(8'hFF);
      @(negedge clk); evt_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = A_FLAG; bus_wdata = 4'h0; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; evt_in = 1'b0;
      repeat (3) @(negedge clk);
      rd_flag(f);
      chk("R11 overflow beats clear", f, 1);
      rd_count(v);
      chk("R11 counter wrapped", v, 8'h00);

      // R6: prescaler rates
      rate_check(3'd1, 2,    64,   "R6 divide by 2");
      rate_check(3'd3, 8,    256,  "R6 divide by 8");
      rate_check(3'd4, 32,   320,  "R6 divide by 32");
      rate_check(3'd7, 2048, 4096, "R6 divide by 2048");

      // random event-mode runs: R5, R7, R8, R9
      for (int it = 0; it < 24; it++) begin
         rel = 1'($urandom % 2);
         tlr = ($urandom % 2) ? (8'hF8 | 8'($urandom % 8)) : 8'($urandom % 256);
         n   = int'($urandom % 6);
         wr(A_MODE, {rel, 3'b000});
         wr(A_FLAG, 4'h0);
         load8(tlr);
         m  = tlr;
         ef = 1'b0;
         for (int k = 0; k < n; k++) begin
            if (m == 8'hFF) ef = 1'b1;
            m = model_step(m, rel, tlr);
            pulse_evt();
         end
         rd_count(v);
         chk(rel ? "R7 random count" : "R8 random count", v, m);
         rd_flag(f);
         chk("R9 random flag", f, ef);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule